// File: doc/BRIEF.md
# Predicate Disjointness Tracking Table

This block keeps, for an in-order predicated pipeline, a record of which predicate definitions can never both be true. Each compare that issues writes two complementary destination predicates. Each destination gets a fresh table entry. Each entry holds a bit-vector with one bit per table entry, and a set bit marks "never true together with that entry". When a compare is guarded by an earlier predicate, both new entries take over everything the guard was already known to be disjoint with. The scoreboard can then drop a dependence between two instructions whose guards are disjoint.

A map from each architectural predicate register to its newest table entry turns register numbers into entry indices. Two lookup ports expose this map. A query port takes two entry indices, each with a valid flag, and answers combinationally whether they are disjoint. Entries are handed out round-robin, two per compare. A flush input wipes all state in one cycle and is the only way to recover from a misprediction.

Top module: `pred_disjoint_table`

## Requirements
- R1: After reset or a flush, every lookup reports no hit, every query reports not disjoint, and the next compare receives entries 0 and 1.
- R2: `cmp_ent_a` shows the entry the next compare will give its first destination. `cmp_ent_b` is `cmp_ent_a`+1 modulo 16. Each accepted compare advances `cmp_ent_a` by 2 modulo 16, so allocation wraps from entries 14,15 back to 0,1.
- R3: The two entries allocated by one compare are reported disjoint with each other.
- R4: A compare whose guard register (nonzero) has a valid map slot gives both new entries every disjointness of the guard's entry, excluding the columns of the two new entries. The new entries are not disjoint with the guard's entry itself.
- R5: A compare with guard register 0 inherits nothing, and only its sibling relation is recorded.
- R6: A compare whose guard register has no valid map slot behaves as if unguarded.
- R7: A compare writing a predicate register overwrites that register's map slot. A later lookup returns the newest entry.
- R8: A query is disjoint when bit B of entry A's vector or bit A of entry B's vector is set. A query with either valid flag low reports not disjoint. No entry is ever disjoint with itself.
- R9: When an entry is reallocated, its column is cleared in every other vector in the same cycle. Every map slot still pointing to it becomes invalid.
- R10: Destination register 0 is never recorded, and a lookup of register 0 never hits.
- R11: A flush takes priority over a compare issued in the same cycle, and the compare has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Clears all table, map and pointer state |
| cmp_valid | input | 1 | A compare issues this cycle |
| cmp_dst_a | input | 6 | First destination predicate register |
| cmp_dst_b | input | 6 | Second (complement) destination predicate register |
| cmp_guard | input | 6 | Guarding predicate register, 0 for none |
| cmp_ent_a | output | 4 | Entry for the next compare's first destination |
| cmp_ent_b | output | 4 | Entry for the next compare's second destination |
| lkp_reg_x | input | 6 | Lookup port X register number |
| lkp_hit_x | output | 1 | Register X has a current entry |
| lkp_ent_x | output | 4 | Entry of register X |
| lkp_reg_y | input | 6 | Lookup port Y register number |
| lkp_hit_y | output | 1 | Register Y has a current entry |
| lkp_ent_y | output | 4 | Entry of register Y |
| qry_ent_a | input | 4 | Query operand A entry |
| qry_va | input | 1 | Operand A is a real entry |
| qry_ent_b | input | 4 | Query operand B entry |
| qry_vb | input | 1 | Operand B is a real entry |
| qry_disjoint | output | 1 | Operands A and B are disjoint |

## Verification
Directed sequences build short chains of compares. An unguarded pair separates the sibling marking from inheritance. A pair guarded by a valid register shows that inheritance happens and that the guard itself stays non-disjoint. A guard with no valid slot, and guard 0, show that nothing is copied in those cases. Running allocation past the wrap point tells column clearing and map invalidation apart from stale entries that survive. Constrained-random compares then run over a small register range, so that redefinitions, repeated guards and occasional flushes occur often. Random lookups and queries in both operand orders are checked against a bench model of the table.

// File: rtl/pred_disjoint_table.sv
module pred_disjoint_table #(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_PREGS   = 64,
  localparam int EW = $clog2(NUM_ENTRIES),
  localparam int PW = $clog2(NUM_PREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          cmp_valid,
  input  logic [PW-1:0] cmp_dst_a,
  input  logic [PW-1:0] cmp_dst_b,
  input  logic [PW-1:0] cmp_guard,
  output logic [EW-1:0] cmp_ent_a,
  output logic [EW-1:0] cmp_ent_b,
  input  logic [PW-1:0] lkp_reg_x,
  output logic          lkp_hit_x,
  output logic [EW-1:0] lkp_ent_x,
  input  logic [PW-1:0] lkp_reg_y,
  output logic          lkp_hit_y,
  output logic [EW-1:0] lkp_ent_y,
  input  logic [EW-1:0] qry_ent_a,
  input  logic          qry_va,
  input  logic [EW-1:0] qry_ent_b,
  input  logic          qry_vb,
  output logic          qry_disjoint
);

  logic [NUM_ENTRIES-1:0][NUM_ENTRIES-1:0] vec;
  logic [NUM_PREGS-1:0]                    map_v;
  logic [EW-1:0]                           map_e [NUM_PREGS];
  logic [EW-1:0]                           ptr;

  logic                   guard_hit;
  logic [NUM_ENTRIES-1:0] gvec, col_keep, new_a, new_b;
  logic                   do_cmp;

  assign cmp_ent_a = ptr;
  assign cmp_ent_b = ptr + EW'(1);
  assign do_cmp    = cmp_valid && !flush;

  assign guard_hit = (cmp_guard != '0) && map_v[cmp_guard];
  assign gvec      = guard_hit ? vec[map_e[cmp_guard]] : '0;
  assign col_keep  = ~((NUM_ENTRIES'(1) << cmp_ent_a) | (NUM_ENTRIES'(1) << cmp_ent_b));
  assign new_a     = (gvec & col_keep) | (NUM_ENTRIES'(1) << cmp_ent_b);
  assign new_b     = (gvec & col_keep) | (NUM_ENTRIES'(1) << cmp_ent_a);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec   <= '0;
      map_v <= '0;
      ptr   <= '0;
    end else if (flush) begin
      vec   <= '0;
      map_v <= '0;
      ptr   <= '0;
    end else if (do_cmp) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (EW'(i) == cmp_ent_a)      vec[i] <= new_a;
        else if (EW'(i) == cmp_ent_b) vec[i] <= new_b;
        else                          vec[i] <= vec[i] & col_keep;
      end
      for (int r = 0; r < NUM_PREGS; r++)
        if (map_e[r] == cmp_ent_a || map_e[r] == cmp_ent_b)
          map_v[r] <= 1'b0;
      if (cmp_dst_a != '0) map_v[cmp_dst_a] <= 1'b1;
      if (cmp_dst_b != '0) map_v[cmp_dst_b] <= 1'b1;
      ptr <= ptr + EW'(2);
    end
  end

  always_ff @(posedge clk) begin
    if (do_cmp) begin
      if (cmp_dst_a != '0) map_e[cmp_dst_a] <= cmp_ent_a;
      if (cmp_dst_b != '0) map_e[cmp_dst_b] <= cmp_ent_b;
    end
  end

  assign lkp_hit_x = (lkp_reg_x != '0) && map_v[lkp_reg_x];
  assign lkp_ent_x = map_e[lkp_reg_x];
  assign lkp_hit_y = (lkp_reg_y != '0) && map_v[lkp_reg_y];
  assign lkp_ent_y = map_e[lkp_reg_y];

  assign qry_disjoint = qry_va && qry_vb &&
                        (vec[qry_ent_a][qry_ent_b] || vec[qry_ent_b][qry_ent_a]);

endmodule

// File: rtl/pred_disjoint_table_chk.sv
module pred_disjoint_table_chk #(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_PREGS   = 64,
  localparam int EW = $clog2(NUM_ENTRIES),
  localparam int PW = $clog2(NUM_PREGS)
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic                                  flush,
  input logic                                  cmp_valid,
  input logic [EW-1:0]                         cmp_ent_a,
  input logic [EW-1:0]                         cmp_ent_b,
  input logic                                  qry_va,
  input logic                                  qry_vb,
  input logic                                  qry_disjoint,
  input logic [PW-1:0]                         lkp_reg_x,
  input logic                                  lkp_hit_x,
  input logic [NUM_ENTRIES-1:0][NUM_ENTRIES-1:0] vec
);

  logic [NUM_ENTRIES-1:0] diag;
  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_diag
    assign diag[i] = vec[i][i];
  end

  AST_FLUSH_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> cmp_ent_a == '0);  // R1
  AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> vec == '0);  // R1
  AST_ALLOC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !flush) |=> cmp_ent_a == EW'($past(cmp_ent_a) + EW'(2)));  // R2
  AST_PAIR_ADJ: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_ent_b == EW'(cmp_ent_a + EW'(1)));  // R2
  AST_SIBLING: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !flush) |=> vec[$past(cmp_ent_a)][$past(cmp_ent_b)] &&
                              vec[$past(cmp_ent_b)][$past(cmp_ent_a)]);  // R3
  AST_NO_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    diag == '0);  // R8
  AST_QRY_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!qry_va || !qry_vb) |-> !qry_disjoint);  // R8
  AST_REG0_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_reg_x == '0) |-> !lkp_hit_x);  // R10
  AST_FLUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && cmp_valid) |=> cmp_ent_a == '0 && vec == '0);  // R11

endmodule

bind pred_disjoint_table pred_disjoint_table_chk #(
  .NUM_ENTRIES(NUM_ENTRIES),
  .NUM_PREGS(NUM_PREGS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .cmp_valid(cmp_valid),
  .cmp_ent_a(cmp_ent_a), .cmp_ent_b(cmp_ent_b),
  .qry_va(qry_va), .qry_vb(qry_vb), .qry_disjoint(qry_disjoint),
  .lkp_reg_x(lkp_reg_x), .lkp_hit_x(lkp_hit_x), .vec(vec)
);

// File: tb/pred_disjoint_table_tb.sv
module pred_disjoint_table_tb;
  localparam int N = 16;
  localparam int P = 64;

  logic clk = 0, rst_n = 0, flush = 0, cmp_valid = 0;
  logic [5:0] cmp_dst_a = 0, cmp_dst_b = 0, cmp_guard = 0;
  logic [3:0] cmp_ent_a, cmp_ent_b;
  logic [5:0] lkp_reg_x = 0, lkp_reg_y = 0;
  logic lkp_hit_x, lkp_hit_y;
  logic [3:0] lkp_ent_x, lkp_ent_y;
  logic [3:0] qry_ent_a = 0, qry_ent_b = 0;
  logic qry_va = 0, qry_vb = 0, qry_disjoint;

  int n_chk = 0, n_fail = 0;

  bit [N-1:0] mvec [N];
  bit         mv   [P];
  int         me   [P];
  int         mptr;

  always #10 clk = ~clk;

  pred_disjoint_table u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .cmp_valid(cmp_valid),
    .cmp_dst_a(cmp_dst_a), .cmp_dst_b(cmp_dst_b), .cmp_guard(cmp_guard),
    .cmp_ent_a(cmp_ent_a), .cmp_ent_b(cmp_ent_b),
    .lkp_reg_x(lkp_reg_x), .lkp_hit_x(lkp_hit_x), .lkp_ent_x(lkp_ent_x),
    .lkp_reg_y(lkp_reg_y), .lkp_hit_y(lkp_hit_y), .lkp_ent_y(lkp_ent_y),
    .qry_ent_a(qry_ent_a), .qry_va(qry_va), .qry_ent_b(qry_ent_b),
    .qry_vb(qry_vb), .qry_disjoint(qry_disjoint)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void model_clear();
    for (int i = 0; i < N; i++) mvec[i] = '0;
    for (int r = 0; r < P; r++) begin mv[r] = 0; me[r] = 0; end
    mptr = 0;
  endfunction

  function automatic void model_cmp(int a, int b, int g);
    int ea = mptr;
    int eb = (mptr + 1) % N;
    bit [N-1:0] gv = (g != 0 && mv[g]) ? mvec[me[g]] : '0;
    bit [N-1:0] keep = ~((N'(1) << ea) | (N'(1) << eb));
    for (int i = 0; i < N; i++) mvec[i] &= keep;
    mvec[ea] = (gv & keep) | (N'(1) << eb);
    mvec[eb] = (gv & keep) | (N'(1) << ea);
    for (int r = 0; r < P; r++) if (mv[r] && (me[r] == ea || me[r] == eb)) mv[r] = 0;
    if (a != 0) begin mv[a] = 1; me[a] = ea; end
    if (b != 0) begin mv[b] = 1; me[b] = eb; end
    mptr = (mptr + 2) % N;
  endfunction

  function automatic int model_qry(int a, int b, bit va, bit vb);
    return (va && vb && (mvec[a][b] || mvec[b][a])) ? 1 : 0;
  endfunction

  task automatic do_cmp(int a, int b, int g, bit fl = 0);
    @(negedge clk);
    cmp_valid = 1; cmp_dst_a = 6'(a); cmp_dst_b = 6'(b); cmp_guard = 6'(g); flush = fl;
    if (fl) model_clear(); else model_cmp(a, b, g);
    @(negedge clk);
    cmp_valid = 0; flush = 0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1; model_clear();
    @(negedge clk);
    flush = 0;
  endtask

  task automatic lookup(string req, int r, int exp_hit, int exp_ent);
    lkp_reg_x = 6'(r); lkp_reg_y = 6'(r); #1;
    check(req, int'(lkp_hit_x), exp_hit);
    check(req, int'(lkp_hit_y), exp_hit);
    if (exp_hit != 0) check(req, int'(lkp_ent_x), exp_ent);
  endtask

  task automatic query(string req, int a, int b, bit va, bit vb, int exp);
    qry_ent_a = 4'(a); qry_ent_b = 4'(b); qry_va = va; qry_vb = vb; #1;
    check(req, int'(qry_disjoint), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    lookup("R1 reset lookup", 5, 0, 0);
    query("R1 reset query", 0, 1, 1, 1, 0);
    check("R1 reset ptr", int'(cmp_ent_a), 0);
    check("R2 pair adjacent", int'(cmp_ent_b), 1);

    // R3 unguarded pair -> entries 0,1
    do_cmp(1, 2, 0);
    lookup("R7 p1 entry", 1, 1, 0);
    lookup("R7 p2 entry", 2, 1, 1);
    query("R3 siblings", 0, 1, 1, 1, 1);
    check("R2 advance", int'(cmp_ent_a), 2);

    // R4 guarded by p1 (entry 0) -> entries 2,3 disjoint with entry 1
    do_cmp(3, 4, 1);
    query("R4 inherit a", 2, 1, 1, 1, 1);
    query("R4 inherit b", 3, 1, 1, 1, 1);
    query("R8 reverse order", 1, 2, 1, 1, 1);
    query("R3 guarded siblings", 2, 3, 1, 1, 1);
    query("R4 not disjoint with guard", 2, 0, 1, 1, 0);

    // R5 guard 0 -> entries 4,5
    do_cmp(5, 6, 0);
    query("R5 no inherit", 4, 1, 1, 1, 0);
    query("R5 sibling only", 4, 5, 1, 1, 1);

    // R6 guard with invalid slot -> entries 6,7
    do_cmp(7, 8, 40);
    query("R6 invalid guard", 6, 1, 1, 1, 0);
    query("R6 invalid guard b", 7, 0, 1, 1, 0);

    // R7 redefinition -> entries 8,9
    do_cmp(1, 9, 0);
    lookup("R7 overwrite", 1, 1, 8);

    // R8 invalid operands
    query("R8 va low", 0, 1, 0, 1, 0);
    query("R8 vb low", 0, 1, 1, 0, 0);
    query("R8 self", 3, 3, 1, 1, 0);

    // R10 dst register 0 -> entries 10,11
    do_cmp(0, 10, 0);
    lookup("R10 reg0 miss", 0, 0, 0);
    lookup("R10 partner recorded", 10, 1, 11);

    // R2/R9 wrap and reuse: entries 12,13 then 14,15 then 0,1
    do_cmp(11, 12, 0);
    do_cmp(13, 14, 0);
    check("R2 before wrap", int'(cmp_ent_a), 0);
    do_cmp(15, 16, 0);
    lookup("R2 wrap entry", 15, 1, 0);
    lookup("R9 stale slot dropped", 2, 0, 0);
    query("R9 column cleared", 2, 1, 1, 1, 0);
    query("R9 column cleared b", 3, 1, 1, 1, 0);
    query("R3 reused siblings", 0, 1, 1, 1, 1);

    // R11 flush beats compare
    do_cmp(20, 21, 0, 1);
    check("R11 ptr after flush", int'(cmp_ent_a), 0);
    lookup("R11 no record", 20, 0, 0);
    lookup("R1 flush clears map", 15, 0, 0);
    query("R1 flush clears vectors", 0, 1, 1, 1, 0);

    // Random phase
    for (int it = 0; it < 600; it++) begin
      int op = $urandom_range(0, 19);
      if (op == 0) do_flush();
      else do_cmp($urandom_range(0, 15), $urandom_range(0, 15),
                  ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(0, 15));
      for (int k = 0; k < 3; k++) begin
        int r = $urandom_range(0, 15);
        int a = $urandom_range(0, N - 1);
        int b = $urandom_range(0, N - 1);
        bit va = ($urandom_range(0, 7) != 0);
        bit vb = ($urandom_range(0, 7) != 0);
        lookup("R7 random lookup", r, (r != 0 && mv[r]) ? 1 : 0, me[r]);
        query("R4 random query", a, b, va, vb, model_qry(a, b, va, vb));
      end
      check("R2 random ptr", int'(cmp_ent_a), mptr);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule